// File: doc/BRIEF.md
# RTC Prescaler with Digital Trim

This block turns a 32.768 kHz counting clock into a one-second tick for a real-time clock and corrects crystal error digitally. Once per trim interval (every 10 s or every 60 s) the final second of that interval is made shorter or longer by a programmed count of 1 to 63 counting-clock cycles. A shorter second makes the clock run fast, and a longer second makes it run slow. Every other second lasts exactly the nominal number of cycles.

Counting only advances while the start input is high. When start is low the divider holds its state, and it resumes from the same point when start returns. The block also produces a sub-second tap that pulses 64 times per nominal second, which drives the 1/64 s periodic event. A ready flag shows when 1/128 s of running time has passed since counting started. The calendar counters and the register bus sit outside this block. The control inputs are plain levels driven from a control register, so there is no streaming interface and no back-pressure.

Top module: `rtc_prescaler`

## Requirements
- R1: With no trim in effect, `sec_tick_o` pulses once every TICKS_PER_SEC cycles of `clk` (32768 by default).
- R2: With `trim_mode_i` = 2'b01 (fast), the last second of each trim interval is shorter by `trim_cycles_i` cycles.
- R3: With `trim_mode_i` = 2'b10 (slow), the last second of each trim interval is longer by `trim_cycles_i` cycles, up to 63.
- R4: The captured interval select sets the trim interval: 1 means every 10 seconds and 0 means every 60 seconds. Seconds are counted from the start of counting.
- R5: Trim is applied only while both `trim_en_i` and `start_i` are high. With `trim_en_i` low, every second is nominal.
- R6: Mode codes 2'b00 and 2'b11 apply no trim.
- R7: `intv10_i` is captured only in cycles where `trim_mode_i` is 2'b00. A change made while the mode is non-zero has no effect on the trim interval.
- R8: While `start_i` is low the divider is frozen and emits no ticks or taps. After start returns, the interrupted second completes with its remaining cycles.
- R9: `ready_o` is low out of reset and goes high after 256 consecutive clock cycles with `start_i` high (1/128 s). It goes low one cycle after `start_i` drops.
- R10: `tap64_o` pulses once every TICKS_PER_SEC/64 cycles, which gives 64 pulses in each nominal second.
- R11: `sec_tick_o` is a single-cycle pulse. After reset, `sec_tick_o`, `tap64_o` and `ready_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz counting clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Counting enable |
| trim_en_i | input | 1 | Automatic trim enable |
| intv10_i | input | 1 | Trim interval select: 1 = 10 s, 0 = 60 s |
| trim_mode_i | input | 2 | 00 none, 01 fast (shorten), 10 slow (lengthen), 11 none |
| trim_cycles_i | input | 6 | Trim amount in counting-clock cycles |
| sec_tick_o | output | 1 | One-second tick pulse |
| tap64_o | output | 1 | 1/64 s tap pulse |
| ready_o | output | 1 | Counters valid (1/128 s elapsed since start) |

## Verification
The assertions check, on every cycle, that ticks, taps and the ready flag stay low while counting is stopped, that a tick never lasts two cycles, that the sub-second count never passes the longest allowed second, and that the captured interval select never moves while a trim mode is programmed. Only the bench scenarios can show the actual second lengths. They measure tick spacing across 60 seconds for fast, slow and no trim under both interval selections, and cover the reserved mode code, the disabled trim, the freeze-and-resume sequence, the tap count per second and the exact cycle at which ready rises.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;

  typedef enum logic [1:0] {
    TRIM_OFF  = 2'b00,
    TRIM_FAST = 2'b01,
    TRIM_SLOW = 2'b10,
    TRIM_RSVD = 2'b11
  } trim_mode_e;

endpackage

// File: rtl/rtc_trim_sched.sv
module rtc_trim_sched
  import rtc_trim_pkg::*;
#(
  parameter int SHORT_SECS = 10,
  parameter int LONG_SECS  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       trim_en_i,
  input  logic       intv10_i,
  input  trim_mode_e mode_i,
  input  logic       wrap_i,
  output logic       trim_add_o,
  output logic       trim_sub_o
);

  localparam int SEC_W = $clog2(LONG_SECS);

  logic             intv_q;
  logic [SEC_W-1:0] sec_q;
  logic [SEC_W-1:0] last_lim;
  logic             at_last;
  logic             trim_ok;

  assign last_lim = intv_q ? SEC_W'(SHORT_SECS - 1) : SEC_W'(LONG_SECS - 1);
  // >= also covers a switch from the long to the short interval mid-way
  assign at_last  = (sec_q >= last_lim);
  assign trim_ok  = start_i && trim_en_i && at_last;

  assign trim_add_o = trim_ok && (mode_i == TRIM_FAST);
  assign trim_sub_o = trim_ok && (mode_i == TRIM_SLOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      intv_q <= 1'b0;
      sec_q  <= '0;
    end else begin
      if (mode_i == TRIM_OFF) begin
        intv_q <= intv10_i;
      end
      if (wrap_i) begin
        sec_q <= at_last ? '0 : sec_q + 1'b1;
      end
    end
  end

  assert_intv_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != TRIM_OFF) |=> $stable(intv_q));

  assert_trim_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(trim_add_o && trim_sub_o));

endmodule

// File: rtl/rtc_sub_div.sv
module rtc_sub_div #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int TRIM_W        = 6,
  parameter int TAP_RATE      = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              add_i,
  input  logic              sub_i,
  input  logic [TRIM_W-1:0] amt_i,
  output logic              wrap_o,
  output logic              tick_o,
  output logic              tap_o
);

  localparam int MAX_LEN    = TICKS_PER_SEC + (1 << TRIM_W);
  localparam int SUB_W      = $clog2(MAX_LEN);
  localparam int TAP_PERIOD = TICKS_PER_SEC / TAP_RATE;
  localparam int TAP_LSB    = $clog2(TAP_PERIOD);
  localparam logic [SUB_W-1:0] BASE_TERM = SUB_W'(TICKS_PER_SEC - 1);

  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] term;
  logic [SUB_W-1:0] amt_ext;
  logic             tap_hit;
  logic             tick_q;
  logic             tap_q;

  assign amt_ext = SUB_W'(amt_i);

  always_comb begin
    term = BASE_TERM;
    if (add_i) begin
      term = BASE_TERM - amt_ext;
    end else if (sub_i) begin
      term = BASE_TERM + amt_ext;
    end
  end

  // >= keeps the count bounded if the trim settings change mid-second
  assign wrap_o = start_i && (sub_q >= term);

  generate
    if (TAP_LSB == 0) begin : g_tap_every
      assign tap_hit = 1'b1;
    end else begin : g_tap_mask
      assign tap_hit = &sub_q[TAP_LSB-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      tick_q <= 1'b0;
      tap_q  <= 1'b0;
    end else begin
      tick_q <= wrap_o;
      tap_q  <= start_i && tap_hit;
      if (start_i) begin
        sub_q <= wrap_o ? '0 : sub_q + 1'b1;
      end
    end
  end

  assign tick_o = tick_q;
  assign tap_o  = tap_q;

  assert_sub_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_q <= SUB_W'(MAX_LEN - 1));

  assert_tick_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !tick_o);

  assert_tap_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !tap_o);

  assert_tick_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

endmodule

// File: rtl/rtc_ready_timer.sv
module rtc_ready_timer #(
  parameter int READY_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic ready_o
);

  localparam int CNT_W = $clog2(READY_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(READY_CYCLES);

  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!start_i) begin
      run_q <= '0;
    end else if (run_q != CNT_DONE) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign ready_o = (run_q == CNT_DONE);

  assert_ready_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> !ready_o);

  assert_ready_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_o) |-> $past(start_i));

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int TRIM_W        = 6,
  parameter int TAP_RATE      = 64,
  parameter int SHORT_SECS    = 10,
  parameter int LONG_SECS     = 60,
  parameter int READY_CYCLES  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              trim_en_i,
  input  logic              intv10_i,
  input  logic [1:0]        trim_mode_i,
  input  logic [TRIM_W-1:0] trim_cycles_i,
  output logic              sec_tick_o,
  output logic              tap64_o,
  output logic              ready_o
);

  trim_mode_e mode;
  logic       wrap;
  logic       trim_add;
  logic       trim_sub;

  assign mode = trim_mode_e'(trim_mode_i);

  rtc_trim_sched #(
    .SHORT_SECS (SHORT_SECS),
    .LONG_SECS  (LONG_SECS)
  ) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .trim_en_i  (trim_en_i),
    .intv10_i   (intv10_i),
    .mode_i     (mode),
    .wrap_i     (wrap),
    .trim_add_o (trim_add),
    .trim_sub_o (trim_sub)
  );

  rtc_sub_div #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .TRIM_W        (TRIM_W),
    .TAP_RATE      (TAP_RATE)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .add_i   (trim_add),
    .sub_i   (trim_sub),
    .amt_i   (trim_cycles_i),
    .wrap_o  (wrap),
    .tick_o  (sec_tick_o),
    .tap_o   (tap64_o)
  );

  rtc_ready_timer #(
    .READY_CYCLES (READY_CYCLES)
  ) u_ready (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .ready_o (ready_o)
  );

endmodule

// File: tb/rtc_prescaler_tb.sv
`timescale 1ns/1ps
module rtc_prescaler_tb;

  localparam int PER = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       trim_en_i = 1'b0;
  logic       intv10_i = 1'b0;
  logic [1:0] trim_mode_i = 2'b00;
  logic [5:0] trim_cycles_i = 6'd0;
  logic       sec_tick_o;
  logic       tap64_o;
  logic       ready_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  rtc_prescaler #(.TICKS_PER_SEC(PER)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .trim_en_i     (trim_en_i),
    .intv10_i      (intv10_i),
    .trim_mode_i   (trim_mode_i),
    .trim_cycles_i (trim_cycles_i),
    .sec_tick_o    (sec_tick_o),
    .tap64_o       (tap64_o),
    .ready_o       (ready_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit en, input bit i10, input logic [5:0] n);
    rst_n = 1'b0;
    start_i = 1'b0;
    trim_en_i = en;
    trim_mode_i = 2'b00;
    intv10_i = i10;
    trim_cycles_i = n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Measure tick spacing for nsec seconds and compare with the arithmetic model
  task automatic run_case(input string req, input bit en, input logic [1:0] md,
                          input logic [5:0] n, input bit i10, input int nsec,
                          input bit toggle);
    int last = 0;
    int k = 0;
    int cyc = 0;
    int taps = 0;
    int nint = i10 ? 10 : 60;
    bit trims = en && (md == 2'b01 || md == 2'b10);
    do_reset(en, i10, n);
    trim_mode_i = md;
    start_i = 1'b1;
    while (k < nsec && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (toggle && cyc == 5) intv10_i = ~i10;
      if (tap64_o) taps++;
      if (sec_tick_o) begin
        if (k > 0) begin
          int exp = PER;
          if (trims && (k % nint) == nint - 1)
            exp = (md == 2'b01) ? PER - int'(n) : PER + int'(n);
          chk(cyc - last == exp, req, cyc - last, exp);
          if (md == 2'b00 && k <= 5)
            chk(taps == 64, "R10 taps per second", taps, 64);
        end
        taps = 0;
        last = cyc;
        k++;
      end
    end
    chk(k == nsec, {req, " tick count"}, k, nsec);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R11: reset state
    do_reset(1'b0, 1'b0, 6'd0);
    chk(sec_tick_o == 1'b0, "R11 tick after reset", int'(sec_tick_o), 0);
    chk(tap64_o == 1'b0, "R11 tap after reset", int'(tap64_o), 0);
    chk(ready_o == 1'b0, "R11 ready after reset", int'(ready_o), 0);

    // R9: ready rises after exactly 256 running cycles
    start_i = 1'b1;
    repeat (255) @(negedge clk);
    chk(ready_o == 1'b0, "R9 ready before 256", int'(ready_o), 0);
    @(negedge clk);
    chk(ready_o == 1'b1, "R9 ready at 256", int'(ready_o), 1);

    // R1 / R10: no trim, 60 s interval and 10 s interval
    run_case("R1 none 60s", 1'b1, 2'b00, 6'd20, 1'b0, 60, 1'b0);
    run_case("R1 none 10s", 1'b1, 2'b00, 6'd20, 1'b1, 30, 1'b0);
    // R2 / R7: fast trim, 60 s, select toggled while mode is non-zero
    run_case("R2 R7 fast 60s", 1'b1, 2'b01, 6'd5, 1'b0, 60, 1'b1);
    // R3: slow trim at maximum, 60 s
    run_case("R3 slow63 60s", 1'b1, 2'b10, 6'd63, 1'b0, 60, 1'b0);
    // R4: 10 s interval with fast and slow trim
    run_case("R4 fast63 10s", 1'b1, 2'b01, 6'd63, 1'b1, 60, 1'b0);
    run_case("R4 slow1 10s", 1'b1, 2'b10, 6'd1, 1'b1, 60, 1'b0);
    // R5: trim disabled
    run_case("R5 enable low", 1'b0, 2'b01, 6'd7, 1'b1, 25, 1'b0);
    // R6: reserved mode code
    run_case("R6 mode 11", 1'b1, 2'b11, 6'd9, 1'b1, 25, 1'b0);

    // R8: freeze and resume
    begin
      int cyc = 0;
      int last = 0;
      int seen = 0;
      int stray = 0;
      do_reset(1'b0, 1'b0, 6'd0);
      start_i = 1'b1;
      while (seen < 2 && cyc < 2000) begin
        @(negedge clk);
        cyc++;
        if (sec_tick_o) begin
          seen++;
          last = cyc;
        end
      end
      start_i = 1'b0;
      repeat (50) begin
        @(negedge clk);
        cyc++;
        if (sec_tick_o || tap64_o) stray++;
      end
      chk(stray == 0, "R8 no pulses while stopped", stray, 0);
      chk(ready_o == 1'b0, "R9 ready low after stop", int'(ready_o), 0);
      start_i = 1'b1;
      seen = 0;
      while (seen < 1 && cyc < 4000) begin
        @(negedge clk);
        cyc++;
        if (sec_tick_o) seen++;
      end
      chk(cyc - last == PER + 50, "R8 resumed second length", cyc - last, PER + 50);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule